// File: doc/BRIEF.md
# Bitonic-Merge Set Intersection Unit

This block finds the IDs that two sorted vertex-ID sets have in common. Each accepted beat carries two vectors of up to `LANES` IDs with an element count for each. The first set is placed unchanged and the second set is placed after it in reverse lane order. Because both sets ascend, this forms a bitonic sequence of `2*LANES` keys. A pipelined bitonic merger turns that sequence into a fully sorted sequence.

After sorting, an ID that appears in both sets sits next to its twin. A final stage flags the left element of each equal pair. It packs the flagged IDs into the low output lanes and reports how many there are as a count and as a lane mask. The network uses `LANES*log2(2*LANES)` comparators. Once the pipeline is full, it produces one result per cycle.

Beats enter and leave on valid/ready streams. A stalled output freezes every stage at once.

Top module: `bitonic_isect`

## Requirements
- R1: Only lanes below `in_a_cnt` of `in_a` and below `in_b_cnt` of `in_b` take part. The values in lanes at or above a set's count have no effect on the result. Either count may be 0.
- R2: Each ID present in both sets appears exactly once in `out_ids`. The IDs sit in lanes 0 upward in ascending order.
- R3: `out_cnt` equals the number of common IDs. `out_mask` has bits 0 to `out_cnt-1` set and all other bits clear.
- R4: Every `out_ids` lane at or above `out_cnt` reads zero.
- R5: With the output free, a beat accepted at clock edge t appears on the output right after edge t+log2(2*LANES). With `LANES`=8, that is five register stages in total.
- R6: While `out_ready` stays high, `in_ready` stays high, and one result leaves per cycle for back-to-back inputs.
- R7: While `out_valid` is high and `out_ready` is low, the output holds stable and `in_ready` is low. No beat is lost or duplicated.
- R8: During reset and right after it, `out_valid` is 0 and `in_ready` is 1.
- R9: Every ID value can match, including all-ones and all-ones minus one. These are the values used to fill unused lanes.
- R10: When the sets share no ID, a result still leaves. Its count is 0, its mask is 0 and its ID lanes are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_a | input | LANES*ID_W | First set, ascending from lane 0 |
| in_a_cnt | input | $clog2(LANES+1) | Number of used lanes in in_a |
| in_b | input | LANES*ID_W | Second set, ascending from lane 0 |
| in_b_cnt | input | $clog2(LANES+1) | Number of used lanes in in_b |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_ids | output | LANES*ID_W | Common IDs packed into the low lanes |
| out_cnt | output | $clog2(LANES+1) | Number of common IDs |
| out_mask | output | LANES | One bit per occupied output lane |

## Verification
The bench builds the unit with `LANES`=8 and `ID_W`=16. This gives a 16-key network of four compare-and-swap stages, so the exact five-cycle latency and gap-free streaming can be counted edge by edge. Sixteen-bit IDs keep the all-ones and all-ones-minus-one values cheap to reach. These two values coincide with the fill values, so the padding-versus-real-ID boundary is exercised. Random sets drawn from a 64-value range give frequent partial overlaps, and directed beats cover empty, single, full-overlap and garbage-in-padding cases.

// File: rtl/bitonic_isect_pkg.sv
package bitonic_isect_pkg;

    parameter int unsigned DEF_LANES = 8;
    parameter int unsigned DEF_ID_W  = 16;

    // width of a count that can hold 0..n
    function automatic int unsigned cnt_bits(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bitonic_isect_cas.sv
module bitonic_isect_cas #(
    parameter int unsigned EW   = 17,
    parameter int unsigned TOT  = 16,
    parameter int unsigned DIST = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv_i,
    input  logic                   vld_i,
    input  logic [TOT-1:0][EW-1:0] el_i,
    output logic                   vld_o,
    output logic [TOT-1:0][EW-1:0] el_o
);

    typedef struct packed {
        logic                   vld;
        logic [TOT-1:0][EW-1:0] el;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.vld = vld_i;
            st_d.el  = el_i;
            for (int i = 0; i < int'(TOT); i++) begin
                if ((i & int'(DIST)) == 0) begin
                    if (el_i[i] > el_i[i + int'(DIST)]) begin
                        st_d.el[i]              = el_i[i + int'(DIST)];
                        st_d.el[i + int'(DIST)] = el_i[i];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign el_o  = st_q.el;

endmodule

// File: rtl/bitonic_isect_match.sv
module bitonic_isect_match #(
    parameter int unsigned LANES = 8,
    parameter int unsigned ID_W  = 16,
    parameter int unsigned CNT_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         adv_i,
    input  logic                         vld_i,
    input  logic [2*LANES-1:0][ID_W:0]   el_i,
    output logic                         vld_o,
    output logic [LANES-1:0][ID_W-1:0]   ids_o,
    output logic [CNT_W-1:0]             cnt_o,
    output logic [LANES-1:0]             mask_o
);

    localparam int unsigned TOT = 2 * LANES;

    typedef struct packed {
        logic                       vld;
        logic [LANES-1:0][ID_W-1:0] ids;
        logic [CNT_W-1:0]           cnt;
        logic [LANES-1:0]           mask;
    } res_t;

    res_t rs_d, rs_q;
    logic [TOT-2:0] hit;

    // left element of each equal pair of real (non-fill) keys
    always_comb begin
        for (int i = 0; i < int'(TOT) - 1; i++) begin
            hit[i] = !el_i[i][ID_W] && !el_i[i+1][ID_W] &&
                     (el_i[i][ID_W-1:0] == el_i[i+1][ID_W-1:0]);
        end
    end

    always_comb begin
        int pos;
        rs_d = rs_q;
        pos  = 0;
        if (adv_i) begin
            rs_d.vld = vld_i;
            rs_d.ids = '0;
            for (int i = 0; i < int'(TOT) - 1; i++) begin
                if (hit[i] && pos < int'(LANES)) begin
                    rs_d.ids[pos] = el_i[i][ID_W-1:0];
                    pos = pos + 1;
                end
            end
            rs_d.cnt = CNT_W'(pos);
            for (int k = 0; k < int'(LANES); k++) begin
                rs_d.mask[k] = (k < pos);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign vld_o  = rs_q.vld;
    assign ids_o  = rs_q.ids;
    assign cnt_o  = rs_q.cnt;
    assign mask_o = rs_q.mask;

    genvar g;
    generate
        for (g = 0; g < TOT - 1; g++) begin : g_ord
            AST_NETWORK_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
                vld_i |-> (el_i[g] <= el_i[g+1])); // R2
        end
    endgenerate

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (cnt_o <= CNT_W'(LANES))); // R3

endmodule

// File: rtl/bitonic_isect.sv
module bitonic_isect
    import bitonic_isect_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned ID_W  = DEF_ID_W,
    parameter int unsigned CNT_W = cnt_bits(LANES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [LANES-1:0][ID_W-1:0] in_a,
    input  logic [CNT_W-1:0]           in_a_cnt,
    input  logic [LANES-1:0][ID_W-1:0] in_b,
    input  logic [CNT_W-1:0]           in_b_cnt,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [LANES-1:0][ID_W-1:0] out_ids,
    output logic [CNT_W-1:0]           out_cnt,
    output logic [LANES-1:0]           out_mask
);

    localparam int unsigned TOT    = 2 * LANES;
    localparam int unsigned STAGES = $clog2(TOT);
    localparam int unsigned EW     = ID_W + 1;
    localparam logic [ID_W-1:0] FILL_A = '1;
    localparam logic [ID_W-1:0] FILL_B = FILL_A - 1'b1;

    logic                   adv;
    logic [TOT-1:0][EW-1:0] seq;
    logic [TOT-1:0][EW-1:0] ch_el [STAGES+1];
    logic                   ch_v  [STAGES+1];

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    // first set in order, second set reversed; the MSB marks fill lanes
    always_comb begin
        for (int i = 0; i < int'(LANES); i++) begin
            seq[i] = (i < int'(in_a_cnt)) ? {1'b0, in_a[i]} : {1'b1, FILL_A};
            seq[int'(LANES) + i] = (int'(LANES) - 1 - i < int'(in_b_cnt)) ?
                {1'b0, in_b[int'(LANES) - 1 - i]} : {1'b1, FILL_B};
        end
    end

    assign ch_el[0] = seq;
    assign ch_v[0]  = in_valid;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            bitonic_isect_cas #(
                .EW   (EW),
                .TOT  (TOT),
                .DIST (TOT >> (s + 1))
            ) u_cas (
                .clk   (clk),
                .rst_n (rst_n),
                .adv_i (adv),
                .vld_i (ch_v[s]),
                .el_i  (ch_el[s]),
                .vld_o (ch_v[s+1]),
                .el_o  (ch_el[s+1])
            );
        end
    endgenerate

    bitonic_isect_match #(
        .LANES (LANES),
        .ID_W  (ID_W),
        .CNT_W (CNT_W)
    ) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (adv),
        .vld_i  (ch_v[STAGES]),
        .el_i   (ch_el[STAGES]),
        .vld_o  (out_valid),
        .ids_o  (out_ids),
        .cnt_o  (out_cnt),
        .mask_o (out_mask)
    );

    AST_MASK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_mask) == int'(out_cnt))); // R3

    AST_HOLD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_ids) && $stable(out_cnt)); // R7

    AST_NO_TAKE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R7

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && (out_cnt <= CNT_W'(k)) |-> (out_ids[k] == '0)); // R4
            if (k < LANES - 1) begin : g_asc
                AST_OUT_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
                    out_valid && (out_cnt > CNT_W'(k + 1)) |-> (out_ids[k] < out_ids[k+1])); // R2
            end
        end
    endgenerate

endmodule

// File: tb/bitonic_isect_tb.sv
module bitonic_isect_tb;

    localparam int LN = 8;
    localparam int IW = 16;
    localparam int CW = 4;

    typedef logic [LN-1:0][IW-1:0] vec_t;

    typedef struct packed {
        vec_t          a;
        logic [CW-1:0] ac;
        vec_t          b;
        logic [CW-1:0] bc;
        logic [CW-1:0] ecnt;
    } stim_t;

    typedef struct packed {
        vec_t          ids;
        logic [CW-1:0] cnt;
    } exp_t;

    // lanes listed 7 down to 0
    localparam stim_t VECS [6] = '{
        '{ {16'd15,16'd13,16'd11,16'd9,16'd7,16'd5,16'd3,16'd1}, 4'd8,
           {16'd9,16'd8,16'd7,16'd6,16'd5,16'd4,16'd3,16'd2},     4'd8, 4'd4 },
        '{ {16'd80,16'd70,16'd60,16'd50,16'd40,16'd30,16'd20,16'd10}, 4'd8,
           {16'd80,16'd70,16'd60,16'd50,16'd40,16'd30,16'd20,16'd10}, 4'd8, 4'd8 },
        '{ {16'd8,16'd7,16'd6,16'd5,16'd3,16'd2,16'd1,16'd0}, 4'd4,
           {16'd0,16'd0,16'd0,16'd8,16'd7,16'd6,16'd5,16'd4}, 4'd5, 4'd0 },
        '{ {16'd7,16'd6,16'd5,16'd4,16'd3,16'd2,16'd1,16'd0}, 4'd0,
           {16'd7,16'd6,16'd5,16'd4,16'd3,16'd2,16'd1,16'd0}, 4'd8, 4'd0 },
        '{ {16'd65534,16'd65535,16'd65534,16'd65535,16'd4,16'd65535,16'd65534,16'd65533}, 4'd3,
           {16'd65535,16'd65534,16'd65533,16'd9,16'd65535,16'd65534,16'd65535,16'd65534}, 4'd2, 4'd2 },
        '{ {16'd100,16'd100,16'd100,16'd100,16'd100,16'd100,16'd100,16'd100}, 4'd1,
           {16'd100,16'd100,16'd100,16'd100,16'd100,16'd100,16'd100,16'd100}, 4'd1, 4'd1 }
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    vec_t          in_a = '0;
    logic [CW-1:0] in_a_cnt = '0;
    vec_t          in_b = '0;
    logic [CW-1:0] in_b_cnt = '0;
    logic          out_valid;
    logic          out_ready;
    vec_t          out_ids;
    logic [CW-1:0] out_cnt;
    logic [LN-1:0] out_mask;

    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    int   mode = 0;
    int   last_acc = 0;
    int   last_out = 0;
    int   waits = 0;
    exp_t expq[$];

    always #10 clk = ~clk;

    bitonic_isect #(.LANES(LN), .ID_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_a_cnt(in_a_cnt), .in_b(in_b), .in_b_cnt(in_b_cnt),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_ids(out_ids), .out_cnt(out_cnt), .out_mask(out_mask)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // output-side ready: 0 free, 1 random stall, 2 blocked
    always @(negedge clk) begin
        if (mode == 0)      out_ready = 1'b1;
        else if (mode == 1) out_ready = ($urandom % 3) != 0;
        else                out_ready = 1'b0;
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic exp_t model(vec_t a, logic [CW-1:0] ac, vec_t b, logic [CW-1:0] bc);
        exp_t e;
        int   n;
        e = '0;
        n = 0;
        for (int i = 0; i < int'(ac); i++)
            for (int j = 0; j < int'(bc); j++)
                if (a[i] == b[j]) begin
                    e.ids[n] = a[i];
                    n++;
                end
        e.cnt = CW'(n);
        return e;
    endfunction

    function automatic logic [LN-1:0] mask_of(logic [CW-1:0] c);
        logic [LN-1:0] m;
        for (int k = 0; k < LN; k++) m[k] = (k < int'(c));
        return m;
    endfunction

    task automatic send(input vec_t a, input logic [CW-1:0] ac, input vec_t b, input logic [CW-1:0] bc);
        @(negedge clk);
        in_valid = 1'b1;
        in_a = a; in_a_cnt = ac; in_b = b; in_b_cnt = bc;
        #1;
        while (!in_ready) begin
            waits++;
            @(negedge clk);
            #1;
        end
        last_acc = cyc + 1;
        expq.push_back(model(a, ac, b, bc));
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic rand_set(output vec_t v, output logic [CW-1:0] c);
        int n;
        int want;
        want = $urandom % (LN + 1);
        n = 0;
        v = '0;
        for (int x = 0; x < 64; x++)
            if (n < want && ($urandom % 4) == 0) begin
                v[n] = IW'(x);
                n++;
            end
        for (int k = n; k < LN; k++) v[k] = IW'($urandom); // garbage in unused lanes (R1)
        c = CW'(n);
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // scoreboard: R2 R3 R4 R10 and R1/R9 through the directed table
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            exp_t e;
            last_out = cyc;
            if (expq.size() == 0) begin
                chk(1'b0, "R7 unexpected result", 128'(out_cnt), 128'd0);
            end else begin
                e = expq.pop_front();
                chk(out_ids == e.ids, "R2/R4 ids", 128'(out_ids), 128'(e.ids));
                chk(out_cnt == e.cnt, "R3 count", 128'(out_cnt), 128'(e.cnt));
                chk(out_mask == mask_of(e.cnt), "R3 mask", 128'(out_mask), 128'(mask_of(e.cnt)));
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", 128'(cyc), 128'd0);
            finish_run();
        end
    end

    initial begin
        vec_t ra, rb;
        logic [CW-1:0] rac, rbc;
        int first;
        vec_t snap;

        repeat (3) @(negedge clk);
        #3;
        chk(out_valid == 1'b0, "R8 valid in reset", 128'(out_valid), 128'd0);
        chk(in_ready == 1'b1, "R8 ready in reset", 128'(in_ready), 128'd1);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        chk(out_valid == 1'b0, "R8 valid after reset", 128'(out_valid), 128'd0);
        chk(in_ready == 1'b1, "R8 ready after reset", 128'(in_ready), 128'd1);

        // table walk: R1 garbage lanes, R9 top values, R10 empty result
        for (int t = 0; t < 6; t++) begin
            exp_t e;
            e = model(VECS[t].a, VECS[t].ac, VECS[t].b, VECS[t].bc);
            chk(e.cnt == VECS[t].ecnt, "R1 table model", 128'(e.cnt), 128'(VECS[t].ecnt));
            send(VECS[t].a, VECS[t].ac, VECS[t].b, VECS[t].bc);
        end
        drain();

        // R5 latency on an empty pipeline
        send(VECS[0].a, VECS[0].ac, VECS[0].b, VECS[0].bc);
        for (int k = 0; k <= 4; k++) begin
            @(negedge clk);
            #3;
            chk(out_valid == (k == 4), "R5 latency", 128'(out_valid), 128'(k == 4));
        end
        drain();

        // R6 back-to-back stream
        waits = 0;
        first = 0;
        for (int n = 0; n < 20; n++) begin
            rand_set(ra, rac);
            rand_set(rb, rbc);
            send(ra, rac, rb, rbc);
            if (n == 0) first = last_acc;
        end
        drain();
        chk(waits == 0, "R6 no input stall", 128'(waits), 128'd0);
        chk(last_out == first + 19 + 4, "R6 one per cycle", 128'(last_out), 128'(first + 23));

        // R7 blocked output holds
        mode = 2;
        @(negedge clk);
        #3;
        send(VECS[1].a, VECS[1].ac, VECS[1].b, VECS[1].bc);
        repeat (6) @(negedge clk);
        #3;
        snap = out_ids;
        chk(out_valid == 1'b1, "R7 result waiting", 128'(out_valid), 128'd1);
        repeat (3) @(negedge clk);
        #3;
        chk(out_valid == 1'b1, "R7 still valid", 128'(out_valid), 128'd1);
        chk(out_ids == snap, "R7 data stable", 128'(out_ids), 128'(snap));
        chk(in_ready == 1'b0, "R7 input blocked", 128'(in_ready), 128'd0);
        mode = 0;
        drain();

        // random traffic with random output stalls: R1 R2 R3 R7
        mode = 1;
        for (int n = 0; n < 300; n++) begin
            rand_set(ra, rac);
            rand_set(rb, rbc);
            if (n % 25 == 0) rb = ra; // full overlap
            if (n % 25 == 0) rbc = rac;
            send(ra, rac, rb, rbc);
        end
        mode = 0;
        drain();
        chk(expq.size() == 0, "R7 nothing lost", 128'(expq.size()), 128'd0);

        finish_run();
    end

endmodule